// File: doc/BRIEF.md
# Synthesizer Divider Configuration Port

This block holds the settings that steer a frequency synthesizer's divider chain: a 9-bit feedback multiplier word, a 2-bit output divide code and a 2-bit observation select. The settings come from one of two sources. A parallel pin bus is transparent while its strobe is low, and the rising strobe edge freezes it. A three-wire serial port shifts a 14-slot frame into a shift register. A load line then copies that register into the settings, and the settings stay frozen after the load line falls. The block also drives a single observation pin. That pin reads low in parallel mode. In serial mode it shows one of four internal signals, chosen by the observation select.

Every pin input is brought into one system clock through a two-stage synchronizer. The edges of the serial clock, the serial load line and the parallel strobe are found by comparing successive synchronized samples. A pin change therefore reaches the settings on the third rising clock edge after it is sampled. A divider reset request is synchronized and forwarded. It never disturbs the stored settings. A flag reports when the stored multiplier lies outside the lockable window, which is 10 to 28 by default.

Top module: `synth_cfg_if`

## Requirements
- R1: After power-up reset the settings are multiplier 16, divide code 00, observation select 00, the range flag is 0 and the observation pin is 0.
- R2: While parStrobe is low, parMul and parDiv are copied to mulVal and divSel on every clock, and a pin change shows at the outputs on the third rising clock edge. testSel is left untouched.
- R3: A rising edge of parStrobe captures parMul and parDiv, and later changes on those pins have no effect while parStrobe stays high.
- R4: In serial mode (parStrobe high), each rising serClk shifts serData into the LSB of a 14-bit shift register. While serLoad stays low, shifting leaves mulVal, divSel and testSel unchanged.
- R5: A rising edge of serLoad copies the shift register into the settings: bits 13:12 to testSel, bits 10:9 to divSel, bits 8:0 to mulVal. Bit 11 (the third slot sent) is ignored. The frame is sent MSB first. After serLoad falls, the settings stay frozen.
- R6: While serLoad is high, every rising serClk shifts and then immediately copies the new shift register contents into the settings.
- R7: In parallel mode, testOut is 0 whatever testSel holds.
- R8: In serial mode, testOut is selected by testSel: 00 gives 0, 01 gives shift register bit 13, 10 gives fbDivIn, and 11 gives outClkIn.
- R9: mulOutOfRange is 1 exactly when mulVal is below MUL_MIN (10) or above MUL_MAX (28).
- R10: divRstReq appears on divRstOut two clock edges later and leaves mulVal, divSel and testSel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-up reset, asynchronous |
| parStrobe | input | 1 | Parallel strobe: low means transparent, a rising edge captures |
| parMul | input | 9 | Parallel multiplier word |
| parDiv | input | 2 | Parallel output divide code |
| serClk | input | 1 | Serial shift clock, sampled |
| serData | input | 1 | Serial data |
| serLoad | input | 1 | Serial transfer/hold line |
| divRstReq | input | 1 | Divider reset request |
| fbDivIn | input | 1 | Feedback divider output to observe |
| outClkIn | input | 1 | Synthesized clock to observe |
| mulVal | output | 9 | Stored multiplier |
| divSel | output | 2 | Stored divide code (00, 01, 10, 11 mean /2, /4, /8, /16) |
| testSel | output | 2 | Stored observation select |
| testOut | output | 1 | Observation pin |
| mulOutOfRange | output | 1 | Multiplier outside the lockable window |
| divRstOut | output | 1 | Synchronized divider reset |

## Verification
A stray shift or a misplaced field shows on the settings outputs at the first serial load that follows. It also shows on testOut within one serial clock once the select is 01, because the top shift bit is then visible at the pin. A bad edge detector either fails to freeze the parallel pins or fails to follow them, and the difference appears three clocks after the pin change. The bench compares every output against a behavioural model on every clock, so each such fault surfaces within a few cycles of the stimulus that provokes it.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  localparam int MUL_W   = 9;
  localparam int DIV_W   = 2;
  localparam int TST_W   = 2;
  localparam int FRAME_W = TST_W + 1 + DIV_W + MUL_W;
  localparam int DIV_LO  = MUL_W;
  localparam int GAP_POS = MUL_W + DIV_W;
  localparam int TST_LO  = GAP_POS + 1;

  typedef struct packed {
    logic parLoad;
    logic shiftEn;
    logic serXfer;
  } cfgStrobe_t;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/cfg_ctrl.sv
module cfg_ctrl
  import synth_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strobeS,
  input  logic       sclkS,
  input  logic       sloadS,
  output cfgStrobe_t strb,
  output logic       parMode
);
  logic strobePrev, sclkPrev, sloadPrev;
  logic strobeRise, clkRise, ldRise, serActive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobePrev <= 1'b1;
      sclkPrev   <= 1'b0;
      sloadPrev  <= 1'b0;
    end else begin
      strobePrev <= strobeS;
      sclkPrev   <= sclkS;
      sloadPrev  <= sloadS;
    end
  end

  assign strobeRise = strobeS & ~strobePrev;
  assign clkRise    = sclkS & ~sclkPrev;
  assign ldRise     = sloadS & ~sloadPrev;
  assign serActive  = strobeS & ~strobeRise;

  always_comb begin
    strb.parLoad = ~strobeS | strobeRise;
    strb.shiftEn = serActive & clkRise;
    strb.serXfer = serActive & sloadS & (clkRise | ldRise);
  end

  assign parMode = ~strobeS;
endmodule

// File: rtl/cfg_datapath.sv
module cfg_datapath
  import synth_cfg_pkg::*;
#(
  parameter int MUL_MIN = 10,
  parameter int MUL_MAX = 28,
  parameter int MUL_RST = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  cfgStrobe_t         strb,
  input  logic               parMode,
  input  logic [MUL_W-1:0]   parMulS,
  input  logic [DIV_W-1:0]   parDivS,
  input  logic               serBit,
  input  logic               fbDivIn,
  input  logic               outClkIn,
  output logic [MUL_W-1:0]   mulVal,
  output logic [DIV_W-1:0]   divSel,
  output logic [TST_W-1:0]   testSel,
  output logic               testOut,
  output logic               mulOutOfRange,
  output logic [FRAME_W-1:0] shiftVal
);
  logic [FRAME_W-1:0] shiftReg, shiftNext;

  assign shiftNext = strb.shiftEn ? {shiftReg[FRAME_W-2:0], serBit} : shiftReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shiftReg <= '0;
    else        shiftReg <= shiftNext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mulVal  <= MUL_W'(MUL_RST);
      divSel  <= '0;
      testSel <= '0;
    end else if (strb.parLoad) begin
      mulVal  <= parMulS;
      divSel  <= parDivS;
    end else if (strb.serXfer) begin
      mulVal  <= shiftNext[MUL_W-1:0];
      divSel  <= shiftNext[DIV_LO +: DIV_W];
      testSel <= shiftNext[TST_LO +: TST_W];
    end
  end

  always_comb begin
    if (parMode) testOut = 1'b0;
    else begin
      case (testSel)
        2'b00:   testOut = 1'b0;
        2'b01:   testOut = shiftReg[FRAME_W-1];
        2'b10:   testOut = fbDivIn;
        default: testOut = outClkIn;
      endcase
    end
  end

  assign mulOutOfRange = (mulVal < MUL_W'(MUL_MIN)) || (mulVal > MUL_W'(MUL_MAX));
  assign shiftVal = shiftReg;
endmodule

// File: rtl/synth_cfg_if.sv
module synth_cfg_if
  import synth_cfg_pkg::*;
#(
  parameter int MUL_MIN = 10,
  parameter int MUL_MAX = 28,
  parameter int MUL_RST = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             parStrobe,
  input  logic [MUL_W-1:0] parMul,
  input  logic [DIV_W-1:0] parDiv,
  input  logic             serClk,
  input  logic             serData,
  input  logic             serLoad,
  input  logic             divRstReq,
  input  logic             fbDivIn,
  input  logic             outClkIn,
  output logic [MUL_W-1:0] mulVal,
  output logic [DIV_W-1:0] divSel,
  output logic [TST_W-1:0] testSel,
  output logic             testOut,
  output logic             mulOutOfRange,
  output logic             divRstOut
);
  localparam int CTL_W = 5;
  localparam int PAR_W = MUL_W + DIV_W;

  logic [CTL_W-1:0]   ctlS;
  logic [PAR_W-1:0]   parS;
  logic [MUL_W-1:0]   parMulS;
  logic [DIV_W-1:0]   parDivS;
  logic               strobeS, sclkS, sdataS, sloadS;
  cfgStrobe_t         strb;
  logic               parMode;
  logic [FRAME_W-1:0] shiftVal;

  cfg_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(5'b10000)) i_ctlSync (
    .clk(clk), .rst_n(rst_n),
    .din({parStrobe, serClk, serData, serLoad, divRstReq}),
    .dout(ctlS));

  cfg_sync #(.W(PAR_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) i_parSync (
    .clk(clk), .rst_n(rst_n),
    .din({parMul, parDiv}),
    .dout(parS));

  assign {strobeS, sclkS, sdataS, sloadS, divRstOut} = ctlS;
  assign {parMulS, parDivS} = parS;

  cfg_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n),
    .strobeS(strobeS), .sclkS(sclkS), .sloadS(sloadS),
    .strb(strb), .parMode(parMode));

  cfg_datapath #(.MUL_MIN(MUL_MIN), .MUL_MAX(MUL_MAX), .MUL_RST(MUL_RST)) i_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .parMode(parMode),
    .parMulS(parMulS), .parDivS(parDivS), .serBit(sdataS),
    .fbDivIn(fbDivIn), .outClkIn(outClkIn),
    .mulVal(mulVal), .divSel(divSel), .testSel(testSel), .testOut(testOut),
    .mulOutOfRange(mulOutOfRange), .shiftVal(shiftVal));
endmodule

// File: rtl/synth_cfg_chk.sv
module synth_cfg_chk
  import synth_cfg_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input cfgStrobe_t         strb,
  input logic               parMode,
  input logic [MUL_W-1:0]   parMulS,
  input logic [FRAME_W-1:0] shiftVal,
  input logic               fbDivIn,
  input logic [MUL_W-1:0]   mulVal,
  input logic [DIV_W-1:0]   divSel,
  input logic [TST_W-1:0]   testSel,
  input logic               testOut
);
  // R2
  par_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.parLoad |=> mulVal == $past(parMulS));

  // R3
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.parLoad && !strb.serXfer) |=> ($stable(mulVal) && $stable(divSel) && $stable(testSel)));

  // R5
  ser_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.serXfer && !strb.shiftEn) |=>
      (testSel == $past(shiftVal[TST_LO +: TST_W]) && divSel == $past(shiftVal[DIV_LO +: DIV_W])
       && mulVal == $past(shiftVal[MUL_W-1:0])));

  // R7
  par_test_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    parMode |-> !testOut);

  // R8
  fb_observe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!parMode && testSel == 2'b10) |-> testOut == fbDivIn);
endmodule

bind synth_cfg_if synth_cfg_chk i_chk (
  .clk(clk), .rst_n(rst_n), .strb(strb), .parMode(parMode), .parMulS(parMulS),
  .shiftVal(shiftVal), .fbDivIn(fbDivIn), .mulVal(mulVal), .divSel(divSel),
  .testSel(testSel), .testOut(testOut));

// File: tb/test_synth_cfg_if.sv
module test_synth_cfg_if;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic parStrobe = 1'b1;
  logic [8:0] parMul = '0;
  logic [1:0] parDiv = '0;
  logic serClk = 1'b0, serData = 1'b0, serLoad = 1'b0, divRstReq = 1'b0;
  logic fbDivIn = 1'b0, outClkIn = 1'b0;
  logic [8:0] mulVal;
  logic [1:0] divSel, testSel;
  logic testOut, mulOutOfRange, divRstOut;

  int nChecks = 0, nFail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  synth_cfg_if i_synth_cfg_if (
    .clk(clk), .rst_n(rst_n), .parStrobe(parStrobe), .parMul(parMul), .parDiv(parDiv),
    .serClk(serClk), .serData(serData), .serLoad(serLoad), .divRstReq(divRstReq),
    .fbDivIn(fbDivIn), .outClkIn(outClkIn), .mulVal(mulVal), .divSel(divSel),
    .testSel(testSel), .testOut(testOut), .mulOutOfRange(mulOutOfRange),
    .divRstOut(divRstOut));

  typedef struct packed {
    logic strobe, sclk, sdata, sload, drst;
    logic [8:0] m;
    logic [1:0] n;
  } pins_t;

  pins_t hist[$];
  int mM, mN, mT;
  logic [13:0] mSr;

  function automatic pins_t idlePins();
    pins_t p = '0;
    p.strobe = 1'b1;
    return p;
  endfunction

  // behavioural reference: pins take two samples to arrive, edges need a third
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = {idlePins(), idlePins(), idlePins()};
      mM = 16; mN = 0; mT = 0; mSr = '0;
    end else begin
      pins_t a, b, cur;
      a = hist[1]; b = hist[2];
      cur = '{parStrobe, serClk, serData, serLoad, divRstReq, parMul, parDiv};
      if (!a.strobe || !b.strobe) begin
        mM = a.m; mN = a.n;
      end else begin
        bit clkR, ldR;
        clkR = a.sclk && !b.sclk;
        ldR  = a.sload && !b.sload;
        if (clkR) mSr = {mSr[12:0], a.sdata};
        if (a.sload && (clkR || ldR)) begin
          mM = mSr[8:0]; mN = mSr[10:9]; mT = mSr[13:12];
        end
      end
      hist.push_front(cur);
      void'(hist.pop_back());
    end
  end

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic expTest();
    if (!hist[1].strobe) return 1'b0;
    case (mT)
      0: return 1'b0;
      1: return mSr[13];
      2: return fbDivIn;
      default: return outClkIn;
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 R3 R5 R6 mulVal", 16'(mulVal), 16'(mM));
      check("R2 R5 divSel", 16'(divSel), 16'(mN));
      check("R4 R5 testSel", 16'(testSel), 16'(mT));
      check("R7 R8 testOut", 16'(testOut), 16'(expTest()));
      check("R9 range flag", 16'(mulOutOfRange), 16'((mM < 10 || mM > 28) ? 1 : 0));
      check("R10 divRstOut", 16'(divRstOut), 16'(hist[1].drst));
    end
  end

  task automatic waitc(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic sendBit(logic b);
    serData = b;
    waitc(3);
    serClk = 1'b1;
    waitc(3);
    serClk = 1'b0;
    waitc(2);
  endtask

  task automatic sendFrame(logic [1:0] t, logic gap, logic [1:0] n, logic [8:0] m);
    logic [13:0] f;
    f = {t, gap, n, m};
    for (int i = 13; i >= 0; i--) sendBit(f[i]);
  endtask

  task automatic pulseLoad();
    serLoad = 1'b1;
    waitc(5);
    serLoad = 1'b0;
    waitc(5);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++; nFail++;
      $display("FAIL R1 watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    waitc(3);
    rst_n = 1'b1;
    waitc(2);
    // R1 defaults
    check("R1 mul default", 16'(mulVal), 16'd16);
    check("R1 div default", 16'(divSel), 16'd0);
    check("R1 test select default", 16'(testSel), 16'd0);
    check("R1 flag default", 16'(mulOutOfRange), 16'd0);
    check("R1 testOut default", 16'(testOut), 16'd0);

    // R4 shifting alone leaves settings
    sendFrame(2'b01, 1'b1, 2'b10, 9'd20);
    check("R4 mul before load", 16'(mulVal), 16'd16);
    pulseLoad();
    check("R5 mul loaded", 16'(mulVal), 16'd20);
    check("R5 div loaded", 16'(divSel), 16'd2);
    check("R5 test select loaded", 16'(testSel), 16'd1);
    check("R8 shift msb low", 16'(testOut), 16'd0);
    sendBit(1'b0);
    check("R8 shift msb high", 16'(testOut), 16'd1);
    check("R4 mul after extra shift", 16'(mulVal), 16'd20);

    // R5 gap slot ignored, R9 below window
    sendFrame(2'b10, 1'b0, 2'b11, 9'd7);
    pulseLoad();
    check("R5 mul gap0", 16'(mulVal), 16'd7);
    check("R9 flag low", 16'(mulOutOfRange), 16'd1);
    sendFrame(2'b10, 1'b1, 2'b11, 9'd7);
    pulseLoad();
    check("R5 mul gap1", 16'(mulVal), 16'd7);
    check("R5 div gap1", 16'(divSel), 16'd3);
    fbDivIn = 1'b1; waitc(1);
    check("R8 fb high", 16'(testOut), 16'd1);
    fbDivIn = 1'b0; waitc(1);
    check("R8 fb low", 16'(testOut), 16'd0);

    // R6 load held high: pass-through on each shift
    serLoad = 1'b1;
    waitc(4);
    sendFrame(2'b11, 1'b0, 2'b01, 9'd28);
    check("R6 mul through", 16'(mulVal), 16'd28);
    check("R6 div through", 16'(divSel), 16'd1);
    check("R6 test select through", 16'(testSel), 16'd3);
    check("R9 flag at max", 16'(mulOutOfRange), 16'd0);
    serLoad = 1'b0;
    waitc(4);
    sendBit(1'b1);
    check("R5 frozen after fall", 16'(mulVal), 16'd28);
    outClkIn = 1'b1; waitc(1);
    check("R8 out clock", 16'(testOut), 16'd1);

    // R2 parallel pass-through, R7 forced low
    parMul = 9'd29; parDiv = 2'b10; parStrobe = 1'b0;
    waitc(4);
    check("R2 mul parallel", 16'(mulVal), 16'd29);
    check("R9 flag above", 16'(mulOutOfRange), 16'd1);
    check("R7 testOut low", 16'(testOut), 16'd0);
    check("R2 test select kept", 16'(testSel), 16'd3);
    parMul = 9'd10; waitc(4);
    check("R2 mul follows", 16'(mulVal), 16'd10);
    check("R9 flag at min", 16'(mulOutOfRange), 16'd0);

    // R3 capture on strobe rise
    parStrobe = 1'b1; waitc(4);
    parMul = 9'd99; parDiv = 2'b00; waitc(6);
    check("R3 mul held", 16'(mulVal), 16'd10);
    check("R3 div held", 16'(divSel), 16'd2);

    // R10 divider reset does not touch settings
    divRstReq = 1'b1; waitc(3);
    check("R10 reset forwarded", 16'(divRstOut), 16'd1);
    check("R10 mul untouched", 16'(mulVal), 16'd10);
    divRstReq = 1'b0; waitc(3);
    check("R10 reset released", 16'(divRstOut), 16'd0);

    // R5 serial load overrides a captured parallel value
    sendFrame(2'b00, 1'b0, 2'b00, 9'd16);
    pulseLoad();
    check("R5 serial after parallel", 16'(mulVal), 16'd16);
    outClkIn = 1'b0;
    waitc(3);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule